// File: doc/BRIEF.md
# Sized Integer Add Execution Unit

This unit carries out one two-operand integer add instruction at a time. It decodes a 16-bit instruction word and reads its operands from an internal bank of eight data registers and eight address registers, each 32 bits. It adds them at byte, word or long size, writes the result back into the low part of a data register, and updates a five-bit condition code register. The unit checks each instruction word for legal forms. A word with an illegal form is rejected. A legal form that would have to touch memory is reported and not executed. An immediate source operand arrives on a separate extension-word port, and the unit waits for each word until it is offered.

A sequencer hands the unit an instruction word with a valid strobe while `busy` is low. When the unit finishes, it raises exactly one of three one-cycle pulses: `done`, `illegal` or `needs_mem`. The whole register and flag state is visible on flat output buses, so a caller can watch the architectural state directly.

Top module: `sadd_unit`

## Requirements
- R1: An instruction is recognised only when bits 15..12 equal 4'b1101. Bits 11..9 name data register Dn. Bits 8..6 hold the op-mode. Op-mode 000, 001 and 010 add ea to Dn and write Dn at byte, word and long size. Op-mode 100, 101 and 110 name ea as the destination. Op-modes 011 and 111, or any other value in bits 15..12, raise `illegal`.
- R2: A byte result changes only bits 7..0 of Dn and a word result changes only bits 15..0. The upper bits keep their previous value.
- R3: C (ccr bit 0) is the carry out of the top bit of the selected size, and X (ccr bit 4) is set equal to C.
- R4: N (ccr bit 3) is the top bit of the result truncated to the selected size. Z (ccr bit 2) is set when that truncated result is zero.
- R5: V (ccr bit 1) is set when the operation overflows as a signed add at the selected size: both operands have the same sign and the result has the other sign.
- R6: As a source, ea mode 000 reads Dn and mode 001 reads An. For word and long sizes, An supplies its low 16 or 32 bits. Mode 001 at byte size raises `illegal`.
- R7: As a destination, ea modes 000 and 001 raise `illegal`, and so do mode 111 with register 010, 011 or 100. In either direction, mode 111 with register 101, 110 or 111 raises `illegal`.
- R8: The following forms pulse `needs_mem` and change no register or flag: source modes 010 to 110, source mode 111 with register 000 to 011, destination modes 010 to 110, and destination mode 111 with register 000 or 001.
- R9: A source of mode 111 with register 100 is an immediate. Byte and word sizes take one extension word, and byte size uses only its low 8 bits. Long size takes two extension words, the high half first. The unit accepts a word only in a cycle where `ext_valid` is high. `busy` stays high while the unit is waiting for a word.
- R10: `done` pulses for one cycle in the cycle after the register write. `illegal` pulses for one cycle in the cycle after the instruction is accepted, and leaves the registers and the flags unchanged. At most one of `done`, `illegal` and `needs_mem` is high at any time.
- R11: After reset, every data register and the ccr read zero, address register An reads (n+1)*A_STEP (A0 = 0x11111111, A7 = 0x88888888 by default), `busy` is low and no pulse is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered; taken when `busy` is low |
| instr_word | input | 16 | Instruction word |
| ext_valid | input | 1 | Extension word offered |
| ext_word | input | 16 | Extension (immediate) word |
| busy | output | 1 | Waiting for extension words |
| done | output | 1 | One-cycle pulse: register operation finished |
| illegal | output | 1 | One-cycle pulse: illegal form rejected |
| needs_mem | output | 1 | One-cycle pulse: legal form needing memory access |
| dregs | output | NREG*DW | Data registers, D0 in the low DW bits |
| aregs | output | NREG*DW | Address registers, A0 in the low DW bits |
| ccr | output | 5 | Flags {X,N,Z,V,C} |

## Verification
Immediates walk a single data register through operand patterns, each chosen to move one flag on its own. A byte add that wraps to zero separates carry from zero. A word add of two large positives separates signed overflow from carry. A long add of two negatives sets carry and overflow together. A source read from an address register checks that only its low part is used. Word and byte adds into a register whose upper bits are non-zero show that those bits survive. Illegal and memory forms are placed between register operations, so any stray write or flag change would show up in the next state check. A stalled extension stream shows that the unit waits and holds its state.

// File: rtl/sadd_pkg.sv
// Package for the sized add unit: operand size, decode result kind,
// condition code layout and the decoded instruction record.
// Assumes a 16-bit instruction word with the operation class in bits 15..12.
package sadd_pkg;

    localparam int          IW       = 16;
    localparam int          EXT_W    = 16;
    localparam logic [3:0]  ADD_LINE = 4'hD;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10
    } size_e;

    typedef enum logic [1:0] {
        K_REG = 2'd0,   // register source, register destination
        K_IMM = 2'd1,   // immediate source, needs extension words
        K_MEM = 2'd2,   // legal but needs memory access
        K_BAD = 2'd3    // illegal combination
    } kind_e;

    // Flag order on the ccr port: bit4 X, bit3 N, bit2 Z, bit1 V, bit0 C.
    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        kind_e      kind;
        size_e      size;
        logic       src_areg;   // source operand is an address register
        logic [2:0] dn;         // data register operand
        logic [2:0] ea_reg;     // register field of the effective address
    } dec_t;

endpackage

// File: rtl/sadd_decode.sv
// Instruction decoder: classifies a word as register, immediate, memory or
// illegal, and extracts the size and register indices.
// Assumes the caller presents a stable word; the logic is purely combinational.
module sadd_decode
    import sadd_pkg::*;
(
    input  logic [IW-1:0] iw,
    input  logic          chk_en,
    output dec_t          dec
);

    logic [2:0] opm;
    logic [2:0] mode;
    logic [2:0] ear;
    logic       to_ea;

    assign opm   = iw[8:6];
    assign mode  = iw[5:3];
    assign ear   = iw[2:0];
    assign to_ea = opm[2];

    // Classify the addressing form per direction and pick the operand size.
    always_comb begin
        dec.dn       = iw[11:9];
        dec.ea_reg   = ear;
        dec.src_areg = 1'b0;
        dec.kind     = K_BAD;
        case (opm[1:0])
            2'b00:   dec.size = SZ_BYTE;
            2'b01:   dec.size = SZ_WORD;
            default: dec.size = SZ_LONG;
        endcase
        if (iw[15:12] == ADD_LINE && opm[1:0] != 2'b11) begin
            if (!to_ea) begin
                case (mode)
                    3'b000: dec.kind = K_REG;
                    3'b001: begin
                        dec.src_areg = 1'b1;
                        dec.kind     = (opm[1:0] == 2'b00) ? K_BAD : K_REG;
                    end
                    3'b111: begin
                        case (ear)
                            3'b000, 3'b001, 3'b010, 3'b011: dec.kind = K_MEM;
                            3'b100:                         dec.kind = K_IMM;
                            default:                        dec.kind = K_BAD;
                        endcase
                    end
                    default: dec.kind = K_MEM;
                endcase
            end else begin
                case (mode)
                    3'b000, 3'b001: dec.kind = K_BAD;
                    3'b111:         dec.kind = (ear[2:1] == 2'b00) ? K_MEM : K_BAD;
                    default:        dec.kind = K_MEM;
                endcase
            end
        end
    end

    // Byte-size source from an address register must never be accepted.
    always_comb begin
        if (chk_en && iw[15:12] == ADD_LINE && iw[8:6] == 3'b000 && iw[5:3] == 3'b001)
            p_byte_areg_r6: assert (dec.kind == K_BAD);
    end

endmodule

// File: rtl/sadd_alu.sv
// Size-aware adder: adds two operands at byte, word or long size and builds
// the five condition flags from the truncated result.
// Assumes DW >= 16; long size uses the full DW width.
module sadd_alu
    import sadd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  size_e         size,
    output logic [DW-1:0] sum,
    output ccr_t          flags
);

    localparam int BW = 8;
    localparam int WW = 16;

    logic [BW:0] s_b;
    logic [WW:0] s_w;
    logic [DW:0] s_l;

    // Three carry-exposing adds, one per size.
    always_comb begin
        s_b = {1'b0, a[BW-1:0]} + {1'b0, b[BW-1:0]};
        s_w = {1'b0, a[WW-1:0]} + {1'b0, b[WW-1:0]};
        s_l = {1'b0, a} + {1'b0, b};
    end

    assign sum = s_l[DW-1:0];

    // Flag selection by size; extend copies carry.
    always_comb begin
        case (size)
            SZ_BYTE: begin
                flags.c = s_b[BW];
                flags.n = s_b[BW-1];
                flags.z = (s_b[BW-1:0] == '0);
                flags.v = (a[BW-1] == b[BW-1]) && (s_b[BW-1] != a[BW-1]);
            end
            SZ_WORD: begin
                flags.c = s_w[WW];
                flags.n = s_w[WW-1];
                flags.z = (s_w[WW-1:0] == '0);
                flags.v = (a[WW-1] == b[WW-1]) && (s_w[WW-1] != a[WW-1]);
            end
            default: begin
                flags.c = s_l[DW];
                flags.n = s_l[DW-1];
                flags.z = (s_l[DW-1:0] == '0);
                flags.v = (a[DW-1] == b[DW-1]) && (s_l[DW-1] != a[DW-1]);
            end
        endcase
        flags.x = flags.c;
    end

    // Long carry means the result wrapped below the first operand; mixed signs never overflow.
    always_comb begin
        if (size == SZ_LONG)
            p_long_carry_r3: assert (flags.c == (sum < a));
        if (size == SZ_BYTE && a[BW-1] != b[BW-1])
            p_mixed_sign_r5: assert (!flags.v);
    end

endmodule

// File: rtl/sadd_regfile.sv
// Register bank: NREG data registers with size-masked writes and NREG address
// registers that load a fixed pattern at reset and are read-only afterwards.
// Assumes one write port and two combinational read ports.
module sadd_regfile
    import sadd_pkg::*;
#(
    parameter int          DW     = 32,
    parameter int          NREG   = 8,
    parameter logic [31:0] A_STEP = 32'h1111_1111,
    localparam int         IDXW   = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDXW-1:0]    wr_idx,
    input  size_e              wr_size,
    input  logic [DW-1:0]      wr_data,
    input  logic [IDXW-1:0]    rd_a_idx,
    input  logic [IDXW-1:0]    rd_b_idx,
    input  logic               rd_b_areg,
    output logic [DW-1:0]      rd_a,
    output logic [DW-1:0]      rd_b,
    output logic [NREG*DW-1:0] dregs_flat,
    output logic [NREG*DW-1:0] aregs_flat
);

    logic [DW-1:0] dreg_q [NREG];
    logic [DW-1:0] areg_q [NREG];
    logic [DW-1:0] wr_mask;

    // Write mask for the selected operand size.
    always_comb begin
        case (wr_size)
            SZ_BYTE: wr_mask = DW'(8'hFF);
            SZ_WORD: wr_mask = DW'(16'hFFFF);
            default: wr_mask = '1;
        endcase
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Data register g: clear on reset, merge masked result on write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dreg_q[g] <= '0;
            else if (wr_en && wr_idx == IDXW'(g))
                dreg_q[g] <= (dreg_q[g] & ~wr_mask) | (wr_data & wr_mask);
        end
        // Address register g: load its reset pattern, then hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                areg_q[g] <= DW'(A_STEP * (g + 1));
        end
        assign dregs_flat[g*DW +: DW] = dreg_q[g];
        assign aregs_flat[g*DW +: DW] = areg_q[g];
    end

    assign rd_a = dreg_q[rd_a_idx];
    assign rd_b = rd_b_areg ? areg_q[rd_b_idx] : dreg_q[rd_b_idx];

    // Snapshot of the register about to be written, for the upper-bit check.
    logic [IDXW-1:0] chk_idx_q;
    logic [DW-1:0]   chk_old_q;
    always_ff @(posedge clk) begin
        chk_idx_q <= wr_idx;
        chk_old_q <= dreg_q[wr_idx];
    end

    p_upper_kept_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_BYTE) |=> (dreg_q[chk_idx_q][DW-1:8] == chk_old_q[DW-1:8]));
    p_upper_kept_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_WORD) |=> (dreg_q[chk_idx_q][DW-1:16] == chk_old_q[DW-1:16]));

endmodule

// File: rtl/sadd_unit.sv
// Top of the sized add unit: accepts an instruction word, collects any
// immediate extension words, performs the add and updates registers and
// flags. Memory forms are only reported. Assumes DW = 2 * EXT_W for long
// immediates and that instructions are offered only while busy is low.
module sadd_unit
    import sadd_pkg::*;
#(
    parameter int          DW     = 32,
    parameter int          NREG   = 8,
    parameter logic [31:0] A_STEP = 32'h1111_1111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [15:0]        instr_word,
    input  logic               ext_valid,
    input  logic [15:0]        ext_word,
    output logic               busy,
    output logic               done,
    output logic               illegal,
    output logic               needs_mem,
    output logic [NREG*DW-1:0] dregs,
    output logic [NREG*DW-1:0] aregs,
    output logic [4:0]         ccr
);

    localparam int IDXW = $clog2(NREG);

    typedef enum logic [1:0] {S_IDLE, S_IMM1, S_IMM2} state_e;

    state_e          state_q;
    logic [IW-1:0]   op_q;
    logic [IW-1:0]   cur_word;
    logic [EXT_W-1:0] imm_hi_q;
    dec_t            dec;
    ccr_t            ccr_q;
    ccr_t            alu_flags;
    logic [DW-1:0]   rd_a;
    logic [DW-1:0]   rd_b;
    logic [DW-1:0]   imm_val;
    logic [DW-1:0]   b_opnd;
    logic [DW-1:0]   alu_sum;
    logic            commit;
    logic            take;
    logic            done_q;
    logic            illegal_q;
    logic            mem_q;

    assign take     = (state_q == S_IDLE) && instr_valid;
    assign cur_word = (state_q == S_IDLE) ? instr_word : op_q;

    sadd_decode u_dec (
        .iw     (cur_word),
        .chk_en (take && rst_n),
        .dec    (dec)
    );

    sadd_regfile #(
        .DW     (DW),
        .NREG   (NREG),
        .A_STEP (A_STEP)
    ) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (commit),
        .wr_idx     (IDXW'(dec.dn)),
        .wr_size    (dec.size),
        .wr_data    (alu_sum),
        .rd_a_idx   (IDXW'(dec.dn)),
        .rd_b_idx   (IDXW'(dec.ea_reg)),
        .rd_b_areg  (dec.src_areg),
        .rd_a       (rd_a),
        .rd_b       (rd_b),
        .dregs_flat (dregs),
        .aregs_flat (aregs)
    );

    // Immediate value: one word zero-extended, or high word held plus low word.
    always_comb begin
        if (state_q == S_IMM2)
            imm_val = DW'({imm_hi_q, ext_word});
        else
            imm_val = DW'(ext_word);
    end

    assign b_opnd = (dec.kind == K_IMM) ? imm_val : rd_b;

    sadd_alu #(.DW(DW)) u_alu (
        .a     (rd_a),
        .b     (b_opnd),
        .size  (dec.size),
        .sum   (alu_sum),
        .flags (alu_flags)
    );

    // Decide when the result and the flags are written.
    always_comb begin
        case (state_q)
            S_IDLE:  commit = instr_valid && dec.kind == K_REG;
            S_IMM1:  commit = ext_valid && dec.size != SZ_LONG;
            S_IMM2:  commit = ext_valid;
            default: commit = 1'b0;
        endcase
    end

    // Sequencer: latch the instruction, then collect extension words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            op_q     <= '0;
            imm_hi_q <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (instr_valid) begin
                        op_q <= instr_word;
                        if (dec.kind == K_IMM)
                            state_q <= S_IMM1;
                    end
                end
                S_IMM1: begin
                    if (ext_valid) begin
                        if (dec.size == SZ_LONG) begin
                            imm_hi_q <= ext_word;
                            state_q  <= S_IMM2;
                        end else begin
                            state_q <= S_IDLE;
                        end
                    end
                end
                S_IMM2: begin
                    if (ext_valid)
                        state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Condition codes change only on a committed add.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ccr_q <= '0;
        else if (commit)
            ccr_q <= alu_flags;
    end

    // One-cycle outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            mem_q     <= 1'b0;
        end else begin
            done_q    <= commit;
            illegal_q <= take && dec.kind == K_BAD;
            mem_q     <= take && dec.kind == K_MEM;
        end
    end

    assign busy      = (state_q != S_IDLE);
    assign done      = done_q;
    assign illegal   = illegal_q;
    assign needs_mem = mem_q;
    assign ccr       = ccr_q;

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_q, illegal_q, mem_q}));
    p_bad_keeps_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> ($stable(dregs) && $stable(ccr_q)));
    p_mem_keeps_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_q |-> ($stable(dregs) && $stable(ccr_q)));
    p_wait_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && !ext_valid) |=> (!done_q && $stable(ccr_q) && busy));

endmodule

// File: tb/tb_sadd_unit.sv
module tb_sadd_unit;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         instr_valid;
    logic [15:0]  instr_word;
    logic         ext_valid;
    logic [15:0]  ext_word;
    logic         busy, done, illegal, needs_mem;
    logic [255:0] dregs, aregs;
    logic [4:0]   ccr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sadd_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .ext_valid(ext_valid), .ext_word(ext_word), .busy(busy), .done(done),
        .illegal(illegal), .needs_mem(needs_mem), .dregs(dregs), .aregs(aregs), .ccr(ccr)
    );

    // kind: 0 done, 1 illegal, 2 needs_mem. ccr bits {X,N,Z,V,C}.
    typedef struct packed {
        logic [3:0]  line;
        logic [2:0]  dn;
        logic [2:0]  opm;
        logic [2:0]  mode;
        logic [2:0]  ear;
        logic [15:0] e0;
        logic [15:0] e1;
        logic [1:0]  kind;
        logic [2:0]  creg;
        logic [31:0] val;
        logic [4:0]  flg;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{4'hD,3'd0,3'b010,3'b111,3'b100,16'h1234,16'h5678,2'd0,3'd0,32'h12345678,5'b00000}, // R9 long imm
        '{4'hD,3'd0,3'b000,3'b111,3'b100,16'hAB88,16'h0000,2'd0,3'd0,32'h12345600,5'b10101}, // R2 R3 R4 byte wrap
        '{4'hD,3'd1,3'b001,3'b111,3'b100,16'h7FFF,16'h0000,2'd0,3'd1,32'h00007FFF,5'b00000},
        '{4'hD,3'd1,3'b001,3'b000,3'b001,16'h0000,16'h0000,2'd0,3'd1,32'h0000FFFE,5'b01010}, // R5 word ovf
        '{4'hD,3'd2,3'b010,3'b001,3'b111,16'h0000,16'h0000,2'd0,3'd2,32'h88888888,5'b01000}, // R6 A7 long
        '{4'hD,3'd2,3'b010,3'b000,3'b010,16'h0000,16'h0000,2'd0,3'd2,32'h11111110,5'b10011}, // R3 R5 long
        '{4'hD,3'd3,3'b000,3'b001,3'b001,16'h0000,16'h0000,2'd1,3'd3,32'h00000000,5'b10011}, // R6 byte An
        '{4'hD,3'd3,3'b001,3'b001,3'b000,16'h0000,16'h0000,2'd0,3'd3,32'h00001111,5'b00000}, // R6 word An
        '{4'hD,3'd3,3'b010,3'b010,3'b000,16'h0000,16'h0000,2'd2,3'd3,32'h00001111,5'b00000}, // R8
        '{4'hD,3'd3,3'b110,3'b000,3'b011,16'h0000,16'h0000,2'd1,3'd3,32'h00001111,5'b00000}, // R7
        '{4'hD,3'd3,3'b110,3'b011,3'b000,16'h0000,16'h0000,2'd2,3'd3,32'h00001111,5'b00000}, // R8
        '{4'hD,3'd3,3'b101,3'b111,3'b001,16'h0000,16'h0000,2'd2,3'd3,32'h00001111,5'b00000}, // R8
        '{4'hD,3'd3,3'b100,3'b111,3'b100,16'h0000,16'h0000,2'd1,3'd3,32'h00001111,5'b00000}, // R7
        '{4'hD,3'd3,3'b110,3'b111,3'b010,16'h0000,16'h0000,2'd1,3'd3,32'h00001111,5'b00000}, // R7
        '{4'hD,3'd3,3'b011,3'b000,3'b000,16'h0000,16'h0000,2'd1,3'd3,32'h00001111,5'b00000}, // R1
        '{4'hD,3'd3,3'b010,3'b111,3'b101,16'h0000,16'h0000,2'd1,3'd3,32'h00001111,5'b00000}, // R7
        '{4'hD,3'd3,3'b010,3'b111,3'b011,16'h0000,16'h0000,2'd2,3'd3,32'h00001111,5'b00000}, // R8
        '{4'hD,3'd3,3'b010,3'b111,3'b100,16'hFFFF,16'hEEEF,2'd0,3'd3,32'h00000000,5'b10101}, // R4 zero
        '{4'hD,3'd2,3'b001,3'b111,3'b100,16'h0010,16'h0000,2'd0,3'd2,32'h11111120,5'b00000}, // R2 word
        '{4'hD,3'd4,3'b000,3'b000,3'b010,16'h0000,16'h0000,2'd0,3'd4,32'h00000020,5'b00000},
        '{4'hC,3'd4,3'b000,3'b000,3'b000,16'h0000,16'h0000,2'd1,3'd4,32'h00000020,5'b00000}, // R1
        '{4'hD,3'd4,3'b000,3'b111,3'b100,16'h0080,16'h0000,2'd0,3'd4,32'h000000A0,5'b01000}, // R4 N
        '{4'hD,3'd1,3'b001,3'b111,3'b100,16'h8000,16'h0000,2'd0,3'd1,32'h00007FFE,5'b10011}  // R5 R2
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] dr(input int n);
        return dregs[n*32 +: 32];
    endfunction

    task automatic run_vec(input vec_t v, input int idx);
        int nw;
        nw = 0;
        if (v.line == 4'hD && v.kind == 2'd0 && v.mode == 3'b111 && v.ear == 3'b100)
            nw = (v.opm[1:0] == 2'b10) ? 2 : 1;
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = {v.line, v.dn, v.opm, v.mode, v.ear};
        @(negedge clk);
        instr_valid = 1'b0;
        for (int w = 0; w < nw; w++) begin
            ext_valid = 1'b1;
            ext_word  = (w == 0) ? v.e0 : v.e1;
            @(negedge clk);
        end
        ext_valid = 1'b0;
        chk($sformatf("R10 vec%0d done", idx),      32'(done),      32'(v.kind == 2'd0));
        chk($sformatf("R7 vec%0d illegal", idx),    32'(illegal),   32'(v.kind == 2'd1));
        chk($sformatf("R8 vec%0d needs_mem", idx),  32'(needs_mem), 32'(v.kind == 2'd2));
        chk($sformatf("R1 R2 vec%0d Dn", idx),      dr(int'(v.creg)), v.val);
        chk($sformatf("R3 R4 R5 vec%0d ccr", idx),  32'(ccr),       32'(v.flg));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0; ext_valid = 1'b0; ext_word = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", 32'(busy), 32'd0);
        chk("R11 pulses", 32'({done, illegal, needs_mem}), 32'd0);
        chk("R11 ccr", 32'(ccr), 32'd0);
        chk("R11 D0", dr(0), 32'd0);
        chk("R11 D7", dr(7), 32'd0);
        chk("R11 A0", aregs[31:0], 32'h11111111);
        chk("R11 A7", aregs[255:224], 32'h88888888);

        for (int i = 0; i < NV; i++)
            run_vec(VEC[i], i);

        // R10: illegal is a single-cycle pulse
        @(negedge clk);
        instr_valid = 1'b1; instr_word = {4'hD, 3'd5, 3'b111, 3'b000, 3'b000};
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R10 illegal pulse", 32'(illegal), 32'd1);
        @(negedge clk);
        chk("R10 illegal one cycle", 32'(illegal), 32'd0);

        // R9: stalled long immediate into D6
        instr_valid = 1'b1; instr_word = {4'hD, 3'd6, 3'b010, 3'b111, 3'b100};
        @(negedge clk);
        instr_valid = 1'b0;
        repeat (3) begin
            chk("R9 busy while waiting hi", 32'(busy), 32'd1);
            chk("R9 no done while waiting", 32'(done), 32'd0);
            @(negedge clk);
        end
        ext_valid = 1'b1; ext_word = 16'h0001;
        @(negedge clk);
        ext_valid = 1'b0; ext_word = 16'hDEAD;
        repeat (2) begin
            chk("R9 busy while waiting lo", 32'(busy), 32'd1);
            chk("R9 D6 untouched while waiting", dr(6), 32'd0);
            @(negedge clk);
        end
        ext_valid = 1'b1; ext_word = 16'h0002;
        @(negedge clk);
        ext_valid = 1'b0;
        chk("R9 stalled done", 32'(done), 32'd1);
        chk("R9 stalled D6", dr(6), 32'h00010002);
        chk("R9 stalled ccr", 32'(ccr), 32'd0);
        @(negedge clk);
        chk("R10 done one cycle", 32'(done), 32'd0);
        chk("R9 idle after", 32'(busy), 32'd0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule